// File: doc/BRIEF.md
# Prioritised Block-Read Request Queue

This block sits in a memory controller, between the accelerator's block-read requests and a word-wide memory read port. The accelerator posts block-read requests into a low-priority queue. Each request gives a source byte address, a length in bytes, a target scratchpad (feature, mean or variance) and a starting word index in that scratchpad. The block splits each request into single-word reads at rising addresses. It writes every returned word into the selected scratchpad at a rising index, so no processor copy is involved.

A second port carries single-word reads from the host processor. These always win over queued block traffic. A block already in service is suspended between words while host reads are pending, and then picks up where it stopped. Illegal requests are consumed and dropped. They raise an error pulse that carries the request's tag. Each completed block raises a done pulse with its tag.

Top module: `blkrd_queue`

## Requirements
- R1: With memory stalled, 17 legal requests are accepted: one moves into the in-service slot and 16 wait in the queue. `lpReady` is then low until a block completes.
- R2: A request is illegal if its byte length is zero, its length is not a multiple of 128, or its destination code is 3. Such a request is accepted, causes no memory read, no scratchpad write and no done pulse, and `errValid` pulses with its tag in the cycle after acceptance.
- R3: A legal block of L bytes at address A issues exactly L/4 memory reads, at addresses A, A+4, A+8 and so on.
- R4: Each word returned for a block is written unchanged. `spWrEn` is one-hot on bit 0 for feature, bit 1 for mean and bit 2 for variance (the destination codes 0, 1 and 2). The index starts at the request's index and rises by one per word, wrapping modulo 1024.
- R5: When `hpValid` is high and no read is outstanding, the memory request carries `hpAddr`. Block words are requested only while `hpValid` is low.
- R6: A host read's data appears on `hpRspValid`/`hpRspData` in the cycle the memory response arrives. It causes no scratchpad write.
- R7: Queued blocks complete in the order they were accepted.
- R8: A block suspended by host reads resumes at the next address and index, with no word lost or repeated.
- R9: `doneValid` pulses with the block's tag in the cycle after its last scratchpad write.
- R10: At most one memory read is outstanding: `memReqValid` stays low from a request handshake until its response.
- R11: After reset `lpReady` is high and `memReqValid`, `spWrEn`, `doneValid`, `errValid` and `hpRspValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lpValid | input | 1 | Block-read request valid |
| lpReady | output | 1 | Queue can take a request |
| lpAddr | input | ADDR_W | Source byte address |
| lpLen | input | LEN_W | Block length in bytes |
| lpDest | input | 2 | Target scratchpad: 0 feature, 1 mean, 2 variance |
| lpIndex | input | IDX_W | First word index in the scratchpad |
| lpTag | input | TAG_W | Request tag |
| hpValid | input | 1 | Host read request valid |
| hpReady | output | 1 | Host read accepted this cycle |
| hpAddr | input | ADDR_W | Host read byte address |
| hpRspValid | output | 1 | Host read data valid |
| hpRspData | output | DATA_W | Host read data |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory accepts request |
| memReqAddr | output | ADDR_W | Memory read byte address |
| memRspValid | input | 1 | Memory read data valid |
| memRspData | input | DATA_W | Memory read data |
| spWrEn | output | 3 | One-hot scratchpad write enable |
| spWrIdx | output | IDX_W | Scratchpad word index |
| spWrData | output | DATA_W | Scratchpad write data |
| doneValid | output | 1 | Block complete pulse |
| doneTag | output | TAG_W | Tag of completed block |
| errValid | output | 1 | Dropped-request pulse |
| errTag | output | TAG_W | Tag of dropped request |

## Verification
The hardest state to reach is a block suspended mid-transfer with host reads waiting. Host traffic must arrive while a block still has words left to issue. The bench waits until several block words have landed, then issues host reads back to back, and checks two things: every request handshake made while `hpValid` was high went to the host address, and the block's write log stays gap-free across the pause. Filling the queue needs the memory port stalled so that the in-service slot cannot drain. The bench holds `memReqReady` low while it enqueues.

// File: rtl/blkrd_pkg.sv
package blkrd_pkg;
  localparam int NUM_SP = 3;

  typedef enum logic {ST_IDLE, ST_WAIT} rdState_e;

  typedef struct packed {
    logic loadActive;
    logic lpIssue;
    logic lpWrite;
  } strobe_t;
endpackage

// File: rtl/blkrd_fifo.sv
module blkrd_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign dout  = store[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !full) store[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push && !full) wrPtr <= nextPtr(wrPtr);
      if (pop && !empty) rdPtr <= nextPtr(rdPtr);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/blkrd_datapath.sv
module blkrd_datapath
  import blkrd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 16,
  parameter int IDX_W       = 10,
  parameter int TAG_W       = 4,
  parameter int DEPTH       = 16,
  parameter int BLOCK_BYTES = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lpValid,
  output logic              lpReady,
  input  logic [ADDR_W-1:0] lpAddr,
  input  logic [LEN_W-1:0]  lpLen,
  input  logic [1:0]        lpDest,
  input  logic [IDX_W-1:0]  lpIndex,
  input  logic [TAG_W-1:0]  lpTag,
  input  strobe_t           strobe,
  output logic              fifoEmpty,
  output logic              actValid,
  output logic              lpHasWork,
  output logic [ADDR_W-1:0] actAddr,
  input  logic [DATA_W-1:0] memRspData,
  output logic [NUM_SP-1:0] spWrEn,
  output logic [IDX_W-1:0]  spWrIdx,
  output logic [DATA_W-1:0] spWrData,
  output logic              doneValid,
  output logic [TAG_W-1:0]  doneTag,
  output logic              errValid,
  output logic [TAG_W-1:0]  errTag
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WORD_SHIFT = $clog2(WORD_BYTES);
  localparam int BLK_SHIFT  = $clog2(BLOCK_BYTES);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  words;
    logic [1:0]        dest;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
  } entry_t;

  entry_t newEntry, headEntry;
  logic   fifoFull, legal, pushEn, dropEn;

  logic [LEN_W-1:0] actIssueLeft, actWriteLeft;
  logic [IDX_W-1:0] actIdx;
  logic [1:0]       actDest;
  logic [TAG_W-1:0] actTag;

  assign legal  = (lpLen != '0) && (lpLen[BLK_SHIFT-1:0] == '0) && (lpDest != 2'd3);
  assign pushEn = lpValid && lpReady && legal;
  assign dropEn = lpValid && lpReady && !legal;
  assign lpReady = !fifoFull;

  always_comb begin
    newEntry.addr  = lpAddr;
    newEntry.words = lpLen >> WORD_SHIFT;
    newEntry.dest  = lpDest;
    newEntry.idx   = lpIndex;
    newEntry.tag   = lpTag;
  end

  blkrd_fifo #(.WIDTH($bits(entry_t)), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rstN  (rstN),
    .push  (pushEn),
    .din   (newEntry),
    .pop   (strobe.loadActive),
    .dout  (headEntry),
    .full  (fifoFull),
    .empty (fifoEmpty)
  );

  assign lpHasWork = actValid && (actIssueLeft != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actValid     <= 1'b0;
      actAddr      <= '0;
      actIssueLeft <= '0;
      actWriteLeft <= '0;
      actIdx       <= '0;
      actDest      <= '0;
      actTag       <= '0;
    end else begin
      if (strobe.loadActive) begin
        actValid     <= 1'b1;
        actAddr      <= headEntry.addr;
        actIssueLeft <= headEntry.words;
        actWriteLeft <= headEntry.words;
        actIdx       <= headEntry.idx;
        actDest      <= headEntry.dest;
        actTag       <= headEntry.tag;
      end
      if (strobe.lpIssue) begin
        actAddr      <= actAddr + ADDR_W'(WORD_BYTES);
        actIssueLeft <= actIssueLeft - 1'b1;
      end
      if (strobe.lpWrite) begin
        actIdx       <= actIdx + 1'b1;
        actWriteLeft <= actWriteLeft - 1'b1;
        if (actWriteLeft == LEN_W'(1)) actValid <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_SP; g++) begin : g_spEn
    assign spWrEn[g] = strobe.lpWrite && (actDest == 2'(g));
  end
  assign spWrIdx  = actIdx;
  assign spWrData = memRspData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      doneTag   <= '0;
      errValid  <= 1'b0;
      errTag    <= '0;
    end else begin
      doneValid <= strobe.lpWrite && (actWriteLeft == LEN_W'(1));
      doneTag   <= actTag;
      errValid  <= dropEn;
      errTag    <= lpTag;
    end
  end
endmodule

// File: rtl/blkrd_ctrl.sv
module blkrd_ctrl
  import blkrd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hpValid,
  output logic              hpReady,
  input  logic [ADDR_W-1:0] hpAddr,
  output logic              hpRspValid,
  input  logic              lpHasWork,
  input  logic              actValid,
  input  logic              fifoEmpty,
  input  logic [ADDR_W-1:0] actAddr,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  output strobe_t           strobe
);
  rdState_e state;
  logic     outIsHp, idle, reqFire;

  assign idle        = (state == ST_IDLE);
  assign memReqValid = idle && (hpValid || lpHasWork);
  assign memReqAddr  = hpValid ? hpAddr : actAddr;
  assign hpReady     = idle && memReqReady;
  assign reqFire     = memReqValid && memReqReady;
  assign hpRspValid  = (state == ST_WAIT) && memRspValid && outIsHp;

  always_comb begin
    strobe.loadActive = !actValid && !fifoEmpty;
    strobe.lpIssue    = reqFire && !hpValid;
    strobe.lpWrite    = (state == ST_WAIT) && memRspValid && !outIsHp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      outIsHp <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqFire) begin
          state   <= ST_WAIT;
          outIsHp <= hpValid;
        end
        ST_WAIT: if (memRspValid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkrd_queue.sv
module blkrd_queue
  import blkrd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 16,
  parameter int IDX_W       = 10,
  parameter int TAG_W       = 4,
  parameter int DEPTH       = 16,
  parameter int BLOCK_BYTES = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lpValid,
  output logic              lpReady,
  input  logic [ADDR_W-1:0] lpAddr,
  input  logic [LEN_W-1:0]  lpLen,
  input  logic [1:0]        lpDest,
  input  logic [IDX_W-1:0]  lpIndex,
  input  logic [TAG_W-1:0]  lpTag,
  input  logic              hpValid,
  output logic              hpReady,
  input  logic [ADDR_W-1:0] hpAddr,
  output logic              hpRspValid,
  output logic [DATA_W-1:0] hpRspData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic [2:0]        spWrEn,
  output logic [IDX_W-1:0]  spWrIdx,
  output logic [DATA_W-1:0] spWrData,
  output logic              doneValid,
  output logic [TAG_W-1:0]  doneTag,
  output logic              errValid,
  output logic [TAG_W-1:0]  errTag
);
  strobe_t           strobe;
  logic              fifoEmpty, actValid, lpHasWork;
  logic [ADDR_W-1:0] actAddr;

  assign hpRspData = memRspData;

  blkrd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hpValid     (hpValid),
    .hpReady     (hpReady),
    .hpAddr      (hpAddr),
    .hpRspValid  (hpRspValid),
    .lpHasWork   (lpHasWork),
    .actValid    (actValid),
    .fifoEmpty   (fifoEmpty),
    .actAddr     (actAddr),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memReqAddr  (memReqAddr),
    .memRspValid (memRspValid),
    .strobe      (strobe)
  );

  blkrd_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .IDX_W(IDX_W),
    .TAG_W(TAG_W), .DEPTH(DEPTH), .BLOCK_BYTES(BLOCK_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .lpValid    (lpValid),
    .lpReady    (lpReady),
    .lpAddr     (lpAddr),
    .lpLen      (lpLen),
    .lpDest     (lpDest),
    .lpIndex    (lpIndex),
    .lpTag      (lpTag),
    .strobe     (strobe),
    .fifoEmpty  (fifoEmpty),
    .actValid   (actValid),
    .lpHasWork  (lpHasWork),
    .actAddr    (actAddr),
    .memRspData (memRspData),
    .spWrEn     (spWrEn),
    .spWrIdx    (spWrIdx),
    .spWrData   (spWrData),
    .doneValid  (doneValid),
    .doneTag    (doneTag),
    .errValid   (errValid),
    .errTag     (errTag)
  );
endmodule

// File: rtl/blkrd_queue_chk.sv
module blkrd_queue_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              lpValid,
  input logic              lpReady,
  input logic              hpValid,
  input logic [ADDR_W-1:0] hpAddr,
  input logic              hpRspValid,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic [2:0]        spWrEn,
  input logic              doneValid,
  input logic              errValid
);
  logic pend;

  always_ff @(posedge clk) begin
    if (!rstN) pend <= 1'b0;
    else if (memReqValid && memReqReady) pend <= 1'b1;
    else if (memRspValid) pend <= 1'b0;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !pend); // R10
  AST_HP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && hpValid) |-> (memReqAddr == hpAddr)); // R5
  AST_SP_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(spWrEn)); // R4
  AST_HP_NO_SPWRITE: assert property (@(posedge clk) disable iff (!rstN)
    hpRspValid |-> (spWrEn == 3'b000)); // R6
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(spWrEn != 3'b000)); // R9
  AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> $past(lpValid && lpReady)); // R2
endmodule

bind blkrd_queue blkrd_queue_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .lpValid     (lpValid),
  .lpReady     (lpReady),
  .hpValid     (hpValid),
  .hpAddr      (hpAddr),
  .hpRspValid  (hpRspValid),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .memRspValid (memRspValid),
  .spWrEn      (spWrEn),
  .doneValid   (doneValid),
  .errValid    (errValid)
);

// File: tb/blkrd_queue_tb.sv
module blkrd_queue_tb;
  localparam int LOGN = 1024;
  localparam int NV   = 7;
  localparam logic [31:0] V_ADDR [NV] = '{32'h1000, 32'h2000, 32'h3000, 32'h4000,
                                         32'h5000, 32'h6000, 32'h7000};
  localparam int V_LEN  [NV] = '{128, 256, 0, 100, 128, 128, 384};
  localparam int V_DEST [NV] = '{0, 1, 2, 0, 3, 2, 1};
  localparam int V_IDX  [NV] = '{0, 100, 7, 3, 9, 1020, 5};

  logic clk = 0, rstN = 0;
  logic lpValid = 0, hpValid = 0, memReqReady = 0, memRspValid = 0;
  logic [31:0] lpAddr = 0, hpAddr = 0, memRspData = 0;
  logic [15:0] lpLen = 0;
  logic [1:0]  lpDest = 0;
  logic [9:0]  lpIndex = 0;
  logic [3:0]  lpTag = 0;
  logic lpReady, hpReady, hpRspValid, memReqValid, doneValid, errValid;
  logic [31:0] hpRspData, memReqAddr, spWrData;
  logic [2:0]  spWrEn;
  logic [9:0]  spWrIdx;
  logic [3:0]  doneTag, errTag;

  blkrd_queue u_dut (.*);

  always #5 clk = ~clk;

  int nChecks = 0, nErr = 0, cyc = 0;
  bit stallMem = 1;
  int rspWait = 0;
  logic [31:0] pendAddr = 0;

  int reqCnt, wrCnt, doneCnt, errCnt, hpCnt, prioViol, hpFireCnt;
  int lastWrCyc, doneCyc, errCyc, acceptCyc;
  logic [31:0] reqAddrLog [LOGN];
  logic [2:0]  wrSelLog [LOGN];
  logic [9:0]  wrIdxLog [LOGN];
  logic [31:0] wrDataLog [LOGN];
  logic [3:0]  doneTagLog [32];
  logic [3:0]  lastErrTag;
  logic [31:0] hpDataLog [16];

  function automatic logic [31:0] dataOf(input logic [31:0] a);
    return a ^ 32'hA5C3_3C5A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearLogs();
    reqCnt = 0; wrCnt = 0; doneCnt = 0; errCnt = 0; hpCnt = 0;
    prioViol = 0; hpFireCnt = 0;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: fixed two-cycle latency, ready pattern with gaps
  always @(negedge clk) begin
    #1;
    memRspValid = 0;
    if (rspWait > 0) begin
      rspWait--;
      if (rspWait == 0) begin
        memRspValid = 1;
        memRspData  = dataOf(pendAddr);
      end
    end
    memReqReady = !stallMem && (cyc % 4 != 2);
    if (memReqValid && memReqReady) begin
      pendAddr = memReqAddr;
      rspWait  = 2;
    end
  end

  // monitor
  always @(negedge clk) begin
    #3;
    if (rstN) begin
      if (memReqValid && memReqReady) begin
        if (reqCnt < LOGN) reqAddrLog[reqCnt] = memReqAddr;
        reqCnt++;
        if (hpValid) begin
          hpFireCnt++;
          if (memReqAddr != hpAddr) prioViol++;
        end
      end
      if (spWrEn != 3'b000) begin
        if (wrCnt < LOGN) begin
          wrSelLog[wrCnt]  = spWrEn;
          wrIdxLog[wrCnt]  = spWrIdx;
          wrDataLog[wrCnt] = spWrData;
        end
        wrCnt++;
        lastWrCyc = cyc;
      end
      if (doneValid) begin
        if (doneCnt < 32) doneTagLog[doneCnt] = doneTag;
        doneCnt++;
        doneCyc = cyc;
      end
      if (errValid) begin
        lastErrTag = errTag;
        errCnt++;
        errCyc = cyc;
      end
      if (lpValid && lpReady) acceptCyc = cyc;
      if (hpRspValid) begin
        if (hpCnt < 16) hpDataLog[hpCnt] = hpRspData;
        hpCnt++;
      end
    end
  end

  task automatic enqueue(input logic [31:0] a, input int len, input int dest,
                         input int idx, input int tag, output bit ok);
    @(negedge clk);
    lpValid = 1; lpAddr = a; lpLen = 16'(len); lpDest = 2'(dest);
    lpIndex = 10'(idx); lpTag = 4'(tag);
    #2 ok = lpReady;
    @(posedge clk);
    @(negedge clk);
    lpValid = 0;
  endtask

  task automatic waitCount(input int target, input bit useDone, input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk); #4;
      if (useDone ? (doneCnt >= target) : (errCnt >= target)) break;
    end
  endtask

  task automatic hpRead(input logic [31:0] a);
    int start;
    bit fire;
    start = hpCnt;
    @(negedge clk);
    hpValid = 1; hpAddr = a;
    for (int i = 0; i < 200; i++) begin
      #2 fire = hpReady;
      @(posedge clk);
      if (fire) break;
      @(negedge clk);
    end
    @(negedge clk);
    hpValid = 0;
    for (int i = 0; i < 50; i++) begin
      if (hpCnt > start) break;
      @(negedge clk); #4;
    end
    chk(hpCnt > start && hpDataLog[start] == dataOf(a), "R6", "host read data",
        longint'(hpDataLog[start]), longint'(dataOf(a)));
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    bit ok;
    int words, bad, nAcc;
    clearLogs();
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk(lpReady == 1 && memReqValid == 0, "R11", "reset lpReady/memReqValid",
        {lpReady, memReqValid}, 2'b10);
    chk(spWrEn == 0 && doneValid == 0 && errValid == 0 && hpRspValid == 0, "R11",
        "reset pulses", {spWrEn, doneValid, errValid, hpRspValid}, 0);
    rstN = 1;
    stallMem = 0;

    // table walk: R2 R3 R4 R9
    for (int v = 0; v < NV; v++) begin
      bit legal;
      clearLogs();
      legal = V_LEN[v] != 0 && V_LEN[v] % 128 == 0 && V_DEST[v] != 3;
      enqueue(V_ADDR[v], V_LEN[v], V_DEST[v], V_IDX[v], v, ok);
      if (legal) begin
        words = V_LEN[v] / 4;
        waitCount(1, 1, 3000);
        repeat (4) @(negedge clk);
        chk(doneCnt == 1 && doneTagLog[0] == 4'(v), "R9", "done tag",
            doneTagLog[0], v);
        chk(doneCyc == lastWrCyc + 1, "R9", "done timing", doneCyc, lastWrCyc + 1);
        chk(reqCnt == words, "R3", "read count", reqCnt, words);
        bad = 0;
        for (int i = 0; i < words && i < LOGN; i++)
          if (reqAddrLog[i] != V_ADDR[v] + 32'(4 * i)) bad++;
        chk(bad == 0, "R3", "read addresses wrong", bad, 0);
        chk(wrCnt == words, "R4", "write count", wrCnt, words);
        bad = 0;
        for (int i = 0; i < words && i < LOGN; i++)
          if (wrSelLog[i] != 3'(1 << V_DEST[v]) ||
              wrIdxLog[i] != 10'(V_IDX[v] + i) ||
              wrDataLog[i] != dataOf(V_ADDR[v] + 32'(4 * i))) bad++;
        chk(bad == 0, "R4", "words wrong", bad, 0);
      end else begin
        waitCount(1, 0, 50);
        repeat (10) @(negedge clk);
        chk(errCnt == 1 && lastErrTag == 4'(v), "R2", "error tag", lastErrTag, v);
        chk(errCyc == acceptCyc + 1, "R2", "error timing", errCyc, acceptCyc + 1);
        chk(reqCnt == 0 && wrCnt == 0 && doneCnt == 0, "R2", "dropped traffic",
            reqCnt + wrCnt + doneCnt, 0);
      end
    end

    // fill with memory stalled: R1, then order R7
    clearLogs();
    stallMem = 1;
    nAcc = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      lpValid = 1; lpAddr = 32'h10000 + 32'(k * 256); lpLen = 16'd128;
      lpDest = 2'(k % 3); lpIndex = 10'(k * 32); lpTag = 4'(k);
      #2 ok = lpReady;
      @(posedge clk);
      if (!ok) break;
      nAcc++;
    end
    @(negedge clk);
    lpValid = 0;
    chk(nAcc == 17, "R1", "accepted before full", nAcc, 17);
    repeat (5) @(negedge clk);
    #2 chk(lpReady == 0, "R1", "ready stays low", lpReady, 0);
    stallMem = 0;
    waitCount(17, 1, 20000);
    bad = 0;
    for (int k = 0; k < 17; k++) if (doneTagLog[k] != 4'(k)) bad++;
    chk(doneCnt == 17 && bad == 0, "R7", "completion order errors", bad, 0);
    chk(wrCnt == 17 * 32, "R7", "total writes", wrCnt, 17 * 32);

    // pause by host reads: R5 R6 R8
    clearLogs();
    enqueue(32'h20000, 256, 1, 200, 9, ok);
    for (int i = 0; i < 500 && wrCnt < 5; i++) begin @(negedge clk); #4; end
    hpRead(32'h9000);
    hpRead(32'h9004);
    hpRead(32'h9008);
    waitCount(1, 1, 3000);
    repeat (4) @(negedge clk);
    chk(prioViol == 0, "R5", "non-host grants while host waiting", prioViol, 0);
    chk(hpFireCnt == 3, "R5", "host grants", hpFireCnt, 3);
    chk(wrCnt == 64, "R8", "writes across pause", wrCnt, 64);
    bad = 0;
    for (int i = 0; i < 64; i++)
      if (wrIdxLog[i] != 10'(200 + i) || wrDataLog[i] != dataOf(32'h20000 + 32'(4 * i)))
        bad++;
    chk(bad == 0, "R8", "resume gaps", bad, 0);
    chk(doneCnt == 1 && doneTagLog[0] == 4'd9, "R9", "paused block done tag",
        doneTagLog[0], 9);

    // host read with nothing queued: R6
    clearLogs();
    hpRead(32'h0000_ABC0);
    chk(wrCnt == 0, "R6", "host read wrote scratchpad", wrCnt, 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule